// File: doc/BRIEF.md
# Accumulator Load/Store Sequencer

This block carries out the four accumulator memory-transfer operations of a small 8-bit processor with a 16-bit address space. Two of them move a byte between the accumulator and the top page of memory, where the low address byte comes from the C register. The other two move a byte between the accumulator and a full 16-bit address supplied as the instruction's immediate operand.

A decoder presents a 2-bit operation code together with the current A and C values and the immediate word, then pulses `start` while the block is idle. The block captures everything it needs on that edge. It counts out the instruction's fixed clock budget in machine cycles of four clocks, and performs the memory access during the final machine cycle. It then raises `done` for exactly one clock. On a load, the byte read from memory is presented on the accumulator write-back port in that same clock.

Top module: `acc_xfer_seq`

## Requirements
- R1: Operation code 0 (bit 1 clear = top-page mode, bit 0 clear = store) writes the captured A value to address 0xFF00 plus the captured C value, with C taken as unsigned.
- R2: Operation code 1 (top-page load) reads address 0xFF00 plus C and returns that byte on `a_wdata` with `a_we` high.
- R3: Both top-page operations occupy exactly 8 clocks. `done` is high in the 8th clock after the edge that accepted `start`, and in no other clock.
- R4: Operation code 2 (bit 1 set = absolute mode, store) writes the captured A value to the captured 16-bit immediate address.
- R5: Operation code 3 (absolute load) reads the captured immediate address and returns that byte on `a_wdata` with `a_we` high.
- R6: Both absolute operations occupy exactly 16 clocks, with `done` high only in the 16th clock.
- R7: The memory strobes are high only during the last 4 clocks of an operation, and never both at once. Address and write data hold steady while a strobe is high. When no strobe is high, `mem_addr` and `mem_wdata` read zero.
- R8: `a_we` is high only in the `done` clock of a load. A store never raises `a_we`.
- R9: A `start` pulse while an operation is in progress is ignored. The running operation keeps its code, address, data and timing, and changes to the operand inputs after acceptance have no effect.
- R10: After reset the block is idle, and `done`, `a_we`, both strobes, `mem_addr` and `mem_wdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation (taken only when idle) |
| op | input | 2 | Operation code: bit 1 absolute mode, bit 0 load |
| a_in | input | 8 | Current accumulator value |
| c_in | input | 8 | Current C register value |
| imm | input | 16 | Immediate 16-bit address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data |
| a_we | output | 1 | Accumulator write enable |
| a_wdata | output | 8 | Accumulator write-back value |
| done | output | 1 | One-clock completion pulse |

## Verification
On every cycle, the assertions check the following: the strobes are exclusive, address and data hold while a strobe is high, accumulator write-back appears only together with a read in the completion clock, stores never write back, and the captured operation is frozen while busy. Other properties can only be shown by the bench's scenarios, which compare against an independent model. These are the exact clock count of each mode, the top-page address arithmetic for every C value including 0x00 and 0xFF, the value returned to A, and the fact that a mid-operation start and operand changes leave the result unchanged.

// File: rtl/acc_xfer_seq.sv
module acc_xfer_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int MCYC_CLKS   = 4,
  parameter int SHORT_MCYCS = 2,
  parameter int LONG_MCYCS  = 4,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] c_in,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              a_we,
  output logic [DATA_W-1:0] a_wdata,
  output logic              done
);
  localparam int SHORT_CLKS = SHORT_MCYCS * MCYC_CLKS;
  localparam int LONG_CLKS  = LONG_MCYCS * MCYC_CLKS;
  localparam int CNT_W      = $clog2(LONG_CLKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CLKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CLKS - 1);
  localparam logic [CNT_W-1:0] ACC_SPAN   = CNT_W'(MCYC_CLKS - 1);

  logic              busy;
  logic [1:0]        op_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  last_cnt;
  logic              access;
  logic [ADDR_W-1:0] high_addr;

  assign high_addr = HIGH_BASE + {{(ADDR_W-DATA_W){1'b0}}, c_in};
  assign last_cnt  = op_q[1] ? LONG_LAST : SHORT_LAST;
  assign access    = busy && (cnt >= last_cnt - ACC_SPAN);
  assign done      = busy && (cnt == last_cnt);

  assign mem_we    = access && !op_q[0];
  assign mem_re    = access &&  op_q[0];
  assign mem_addr  = access ? addr_q : '0;
  assign mem_wdata = mem_we ? data_q : '0;
  assign a_we      = done && op_q[0];
  assign a_wdata   = a_we ? mem_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_q   <= '0;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        op_q   <= op;
        cnt    <= '0;
        addr_q <= op[1] ? imm : high_addr;
        data_q <= a_in;
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && $past(mem_we || mem_re)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_DONE_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_we && !mem_re && !done)); // R7
  AST_AWE_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> (done && mem_re)); // R8
  AST_STORE_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !a_we); // R8
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_q) && $stable(addr_q) && $stable(data_q))); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LONG_LAST)); // R6
endmodule

// File: tb/tb_acc_xfer_seq.sv
`timescale 1ns/1ps
module tb_acc_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [7:0]  a_in = '0, c_in = '0;
  logic [15:0] imm = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, a_wdata;
  logic        mem_we, mem_re, a_we, done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] ad);
    return ad[7:0] ^ {ad[11:8], ad[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [1:0] o, input logic [7:0] c, input logic [15:0] i);
    return o[1] ? i : (16'hFF00 + {8'h00, c});
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  acc_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in), .c_in(c_in),
    .imm(imm), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .a_we(a_we), .a_wdata(a_wdata), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one operation; if poke is set, a second start and new operands are driven mid-way.
  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [7:0] c,
                        input logic [15:0] i, input bit poke);
    int n = o[1] ? 16 : 8;
    logic [15:0] ea = exp_addr(o, c, i);
    int done_at = 0;
    bit strobe_ok = 1'b1, idle_ok = 1'b1, data_ok = 1'b1, awe_ok = 1'b1;
    @(negedge clk);
    start = 1'b1; op = o; a_in = a; c_in = c; imm = i;
    @(negedge clk);
    start = 1'b0;
    a_in = ~a; c_in = c + 8'd1; imm = ~i;
    for (int k = 1; k <= n; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; op = ~o;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        if (done_at == 0) done_at = k;
        else done_at = -1;
      end
      if (k > n - 4) begin
        if (mem_addr != ea || mem_we != !o[0] || mem_re != o[0]) strobe_ok = 1'b0;
        if (!o[0] && mem_wdata != a) data_ok = 1'b0;
      end else begin
        if (mem_we || mem_re || mem_addr != 0 || mem_wdata != 0) idle_ok = 1'b0;
      end
      if (k == n && o[0]) begin
        if (!a_we || a_wdata != mem_byte(ea)) awe_ok = 1'b0;
      end else if (a_we) awe_ok = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (done) done_at = -1;
    if (o[1]) begin
      check(done_at == n, "R6 clock count", done_at, n);
      if (o[0]) check(strobe_ok, "R5 absolute load address", mem_addr, ea);
      else      check(strobe_ok && data_ok, "R4 absolute store", mem_addr, ea);
    end else begin
      check(done_at == n, "R3 clock count", done_at, n);
      if (o[0]) check(strobe_ok, "R2 high-page load address", mem_addr, ea);
      else      check(strobe_ok && data_ok, "R1 high-page store", mem_addr, ea);
    end
    check(idle_ok, "R7 strobes only in last machine cycle", {mem_we, mem_re}, 0);
    if (o[0]) check(awe_ok, o[1] ? "R5 write-back value" : "R2 write-back value", a_wdata, mem_byte(ea));
    else      check(awe_ok, "R8 store leaves A untouched", a_we, 0);
    if (poke) check(done_at == n && strobe_ok, "R9 start while busy ignored", done_at, n);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!done && !a_we && !mem_we && !mem_re && mem_addr == 0 && mem_wdata == 0,
          "R10 reset state", {done, a_we, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_we && !mem_re, "R10 idle after reset", {done, mem_we, mem_re}, 0);
    run_op(2'd0, 8'hA5, 8'h00, 16'h1234, 1'b0);
    run_op(2'd0, 8'h3C, 8'hFF, 16'h0000, 1'b0);
    run_op(2'd1, 8'h11, 8'h80, 16'hBEEF, 1'b0);
    run_op(2'd1, 8'h00, 8'hFF, 16'h0000, 1'b0);
    run_op(2'd2, 8'h77, 8'h01, 16'h0000, 1'b0);
    run_op(2'd3, 8'h00, 8'h01, 16'hFFFF, 1'b0);
    run_op(2'd1, 8'h99, 8'h42, 16'h4321, 1'b1);
    run_op(2'd2, 8'hC3, 8'h10, 16'h8001, 1'b1);
    for (int t = 0; t < 40; t++) begin
      run_op(2'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) @(negedge clk);
    end
    @(negedge clk);
    check(!done && !mem_we && !mem_re, "R9 idle between operations", {done, mem_we, mem_re}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule